// File: doc/BRIEF.md
# Write-Back Store Cache with Split Miss Channels

This block is a private write-back data cache placed behind a small write-through data cache in a processor tile. Every store that the upper cache writes through lands here and stays here, marked dirty, until the line is chosen as a victim. Loads that hit return a word from the local array. Loads and stores that miss fetch the whole line from a shared last-level cache (a store miss allocates the line and merges its word into it). Instruction fetches are never allocated: they go straight out to the shared cache and the returned word goes straight back to the core.

Traffic towards the shared cache uses three independent valid/ready channels. Line requests go out on one, fill lines come back on a second, and dirty victims leave on a third. A dirty victim is written back before the request for the new line goes out. Inclusion with the upper cache is kept by pulsing an invalidate for any valid line that is evicted. Only one miss is in flight at a time: the core port stays closed from when a request is accepted until its response. The default geometry is 8 KB, 4 ways and 16-byte lines. Replacement uses a per-set pseudo-LRU tree that does not depend on the upper cache's policy.

Top module: `sc_store_cache`

## Requirements
- R1: After reset the core port is ready, no response, invalidate, line request or writeback is valid, and every line is invalid, so the first access to any address misses.
- R2: A load (op code 0) to a line that is present returns the addressed 32-bit word and causes no traffic on any network channel. Address bits [3:2] pick word k, held at fill-line bits [32k+31:32k].
- R3: A load miss issues exactly one line request whose address is the access address with bits [3:0] cleared and whose fetch flag is 0. The response carries the requested word from the fill line, and the line is then present.
- R4: A store (op code 1) that hits replaces one word of the line and marks it dirty with no network traffic. A store that misses fetches the line, merges its word and marks the line dirty. Both kinds acknowledge with a response carrying the stored word.
- R5: Evicting a dirty line sends the whole victim line and its line address on the writeback channel. That transfer completes before the line request for the new line becomes valid.
- R6: Evicting a clean line produces no writeback.
- R7: Evicting a valid line pulses the upper-level invalidate for one cycle with the victim's line address. Filling an invalid way pulses no invalidate.
- R8: An instruction fetch (op code 2) sends a line request with the fetch flag set and returns the addressed word from the fill line. It allocates nothing, so a later load to that line misses, and it never invalidates. Op code 3 behaves as a load.
- R9: From the cycle after a request is accepted until the cycle its response is valid, the core port is not ready. The response is valid for exactly one cycle.
- R10: A miss fills the lowest-numbered invalid way of the set. If all ways are valid it evicts the way chosen by a binary tree with one bit per node: the root picks the way-number MSB, and each node's bit names the half to evict. Every hit or fill sets the nodes on the way's path to point at the other half. After filling ways 0,1,2,3 of a set in order and hitting way 0 again, the next miss evicts way 2.
- R11: Once a line request or writeback is valid, it stays valid with unchanged address (and data) until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_valid | input | 1 | Core request valid |
| core_req_ready | output | 1 | Core request accepted this cycle when valid |
| core_req_op | input | 2 | 0 load, 1 store, 2 instruction fetch, 3 load |
| core_req_addr | input | ADDR_W | Byte address of the word |
| core_req_wdata | input | WORD_W | Store data |
| core_resp_valid | output | 1 | One-cycle response pulse |
| core_resp_data | output | WORD_W | Loaded or fetched word, or the stored word for a store |
| up_inv_valid | output | 1 | Invalidate pulse towards the upper cache |
| up_inv_addr | output | ADDR_W | Line address to invalidate |
| mreq_valid | output | 1 | Line request valid |
| mreq_ready | input | 1 | Line request accepted |
| mreq_addr | output | ADDR_W | Line-aligned request address |
| mreq_ifetch | output | 1 | Request is an uncached instruction fetch |
| fill_valid | input | 1 | Fill line valid |
| fill_ready | output | 1 | Cache waits for a fill |
| fill_data | input | LINE_BYTES*8 | Fill line |
| wb_valid | output | 1 | Writeback valid |
| wb_ready | input | 1 | Writeback accepted |
| wb_addr | output | ADDR_W | Line address of the dirty victim |
| wb_data | output | LINE_BYTES*8 | Dirty victim line |

## Verification
The bench drives one set through all four ways and checks that replacement follows the tree. A design with a plain round-robin or a wrong node update would evict the dirty line instead of the clean one, or evict the line that was just hit. It stalls the writeback channel and checks that the line request stays idle until the writeback is taken. An overlap of the two would let the shared cache serve stale data, and the bench sees that when it reloads the evicted dirty word. It checks that an instruction fetch leaves the set untouched, since an allocating bypass would make the next load hit silently. It also checks that stores into free ways raise no invalidate, because a spurious invalidate would only cost performance and would otherwise go unnoticed.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int SC_ADDR_W = 32;
    localparam int SC_WORD_W = 32;

    localparam logic [1:0] SC_OP_LOAD   = 2'd0;
    localparam logic [1:0] SC_OP_STORE  = 2'd1;
    localparam logic [1:0] SC_OP_IFETCH = 2'd2;

    typedef enum logic [1:0] {
        KIND_LOAD,
        KIND_STORE,
        KIND_FETCH
    } sc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WB,
        ST_REQ,
        ST_FILL
    } sc_state_e;

    function automatic sc_kind_e decode_op(input logic [1:0] op);
        case (op)
            SC_OP_STORE:  return KIND_STORE;
            SC_OP_IFETCH: return KIND_FETCH;
            default:      return KIND_LOAD;
        endcase
    endfunction

endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store #(
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int TAG_W = 21,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDX_W-1:0]      rd_idx,
    input  logic [TAG_W-1:0]      rd_tag,
    output logic                  hit_any,
    output logic [WAY_W-1:0]      hit_way,
    output logic                  free_any,
    output logic [WAY_W-1:0]      free_way,
    output logic [WAYS-1:0]       valid_o,
    output logic [WAYS-1:0]       dirty_o,
    output logic [WAYS*TAG_W-1:0] tags_o,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [WAY_W-1:0]      wr_way,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic                  wr_dirty
);

    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else if (wr_en) begin
            valid_q[wr_idx][wr_way] <= 1'b1;
            dirty_q[wr_idx][wr_way] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx][wr_way] <= wr_tag;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = valid_q[rd_idx][w] && (tag_q[rd_idx][w] == rd_tag);
        assign tags_o[w*TAG_W +: TAG_W] = tag_q[rd_idx][w];
    end

    assign valid_o = valid_q[rd_idx];
    assign dirty_o = dirty_q[rd_idx];

    always_comb begin
        hit_any  = 1'b0;
        hit_way  = '0;
        free_any = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit_any = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (!valid_o[w]) begin
                free_any = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
    parameter int SETS   = 128,
    parameter int WAYS   = 4,
    parameter int LINE_W = 128,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WAY_W-1:0]  rd_way,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [LINE_W-1:0] wr_line
);

    logic [LINE_W-1:0] line_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_idx][wr_way] <= wr_line;
        end
    end

    assign rd_line = line_q[rd_idx][rd_way];

endmodule

// File: rtl/sc_plru_unit.sv
module sc_plru_unit #(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    output logic [WAY_W-1:0] victim_way,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [WAY_W-1:0] touch_way
);

    // one bit per tree node; node 0 is the root, children of n are 2n+1 and 2n+2
    logic [WAYS-1:0] tree_q [SETS];
    logic [WAYS-1:0] tree_rd;
    logic [WAYS-1:0] tree_touched;

    assign tree_rd = tree_q[idx];

    always_comb begin
        logic [WAY_W-1:0] node;
        logic [WAY_W:0]   next;
        logic             bit_v;
        node       = '0;
        victim_way = '0;
        for (int l = 0; l < WAY_W; l++) begin
            bit_v = tree_rd[node];
            victim_way[WAY_W-1-l] = bit_v;
            next = {node, 1'b0} + (WAY_W+1)'(1) + (WAY_W+1)'(bit_v);
            node = next[WAY_W-1:0];
        end
    end

    always_comb begin
        logic [WAY_W-1:0] node;
        logic [WAY_W:0]   next;
        logic             dir;
        tree_touched = tree_q[touch_idx];
        node         = '0;
        for (int l = 0; l < WAY_W; l++) begin
            dir = touch_way[WAY_W-1-l];
            tree_touched[node] = ~dir;
            next = {node, 1'b0} + (WAY_W+1)'(1) + (WAY_W+1)'(dir);
            node = next[WAY_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                tree_q[s] <= '0;
            end
        end else if (touch_en) begin
            tree_q[touch_idx] <= tree_touched;
        end
    end

endmodule

// File: rtl/sc_store_cache.sv
module sc_store_cache
    import sc_pkg::*;
#(
    parameter int ADDR_W      = SC_ADDR_W,
    parameter int WORD_W      = SC_WORD_W,
    parameter int CACHE_BYTES = 8192,
    parameter int WAYS        = 4,
    parameter int LINE_BYTES  = 16,
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_req_valid,
    output logic              core_req_ready,
    input  logic [1:0]        core_req_op,
    input  logic [ADDR_W-1:0] core_req_addr,
    input  logic [WORD_W-1:0] core_req_wdata,
    output logic              core_resp_valid,
    output logic [WORD_W-1:0] core_resp_data,
    output logic              up_inv_valid,
    output logic [ADDR_W-1:0] up_inv_addr,
    output logic              mreq_valid,
    input  logic              mreq_ready,
    output logic [ADDR_W-1:0] mreq_addr,
    output logic              mreq_ifetch,
    input  logic              fill_valid,
    output logic              fill_ready,
    input  logic [LINE_W-1:0] fill_data,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0] wb_data
);

    localparam int SETS   = CACHE_BYTES / (LINE_BYTES * WAYS);
    localparam int WPL    = LINE_BYTES / (WORD_W / 8);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BSEL_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(WPL);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W  = $clog2(WAYS);

    typedef struct packed {
        sc_kind_e          kind;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } sc_req_t;

    sc_state_e        state;
    sc_req_t          r_req;
    logic [WAY_W-1:0] r_way;

    logic [IDX_W-1:0]  r_idx;
    logic [TAG_W-1:0]  r_tag;
    logic [WSEL_W-1:0] r_wsel;
    logic              is_store;
    logic              is_fetch;

    logic              hit_any, free_any;
    logic [WAY_W-1:0]  hit_way, free_way, plru_way, victim_way, rd_way;
    logic [WAYS-1:0]   valid_set, dirty_set;
    logic [WAYS*TAG_W-1:0] tags_set;
    logic              vic_valid, vic_dirty;
    logic [TAG_W-1:0]  vic_tag;
    logic [LINE_W-1:0] rd_line;

    logic              look_hit, fill_take, line_write;
    logic [WAY_W-1:0]  wr_way;
    logic [LINE_W-1:0] base_line, wr_line;

    logic unused_addr_bits;

    function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                    input logic [WSEL_W-1:0] sel);
        return line[sel*WORD_W +: WORD_W];
    endfunction

    function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] line,
                                                   input logic [WSEL_W-1:0] sel,
                                                   input logic [WORD_W-1:0] w);
        logic [LINE_W-1:0] t;
        t = line;
        t[sel*WORD_W +: WORD_W] = w;
        return t;
    endfunction

    assign r_idx    = r_req.addr[OFF_W +: IDX_W];
    assign r_tag    = r_req.addr[ADDR_W-1 -: TAG_W];
    assign r_wsel   = r_req.addr[BSEL_W +: WSEL_W];
    assign is_store = (r_req.kind == KIND_STORE);
    assign is_fetch = (r_req.kind == KIND_FETCH);
    assign unused_addr_bits = ^r_req.addr[BSEL_W-1:0];

    sc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (r_idx),
        .rd_tag   (r_tag),
        .hit_any  (hit_any),
        .hit_way  (hit_way),
        .free_any (free_any),
        .free_way (free_way),
        .valid_o  (valid_set),
        .dirty_o  (dirty_set),
        .tags_o   (tags_set),
        .wr_en    (line_write),
        .wr_idx   (r_idx),
        .wr_way   (wr_way),
        .wr_tag   (r_tag),
        .wr_dirty (is_store)
    );

    sc_plru_unit #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk        (clk),
        .rst        (rst),
        .idx        (r_idx),
        .victim_way (plru_way),
        .touch_en   (look_hit || fill_take),
        .touch_idx  (r_idx),
        .touch_way  (wr_way)
    );

    sc_data_store #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) u_data (
        .clk     (clk),
        .rd_idx  (r_idx),
        .rd_way  (rd_way),
        .rd_line (rd_line),
        .wr_en   (line_write),
        .wr_idx  (r_idx),
        .wr_way  (wr_way),
        .wr_line (wr_line)
    );

    // victim: lowest free way first, tree choice otherwise
    assign victim_way = free_any ? free_way : plru_way;
    assign rd_way     = hit_any ? hit_way : victim_way;
    assign vic_valid  = valid_set[victim_way];
    assign vic_dirty  = dirty_set[victim_way];
    assign vic_tag    = tags_set[victim_way*TAG_W +: TAG_W];

    assign look_hit   = (state == ST_LOOK) && hit_any;
    assign fill_take  = (state == ST_FILL) && fill_valid && !is_fetch;
    assign line_write = (look_hit && is_store) || fill_take;
    assign wr_way     = (state == ST_LOOK) ? hit_way : r_way;
    assign base_line  = (state == ST_LOOK) ? rd_line : fill_data;
    assign wr_line    = is_store ? put_word(base_line, r_wsel, r_req.wdata) : base_line;

    assign core_req_ready = (state == ST_IDLE);
    assign mreq_valid     = (state == ST_REQ);
    assign mreq_addr      = {r_req.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mreq_ifetch    = is_fetch;
    assign wb_valid       = (state == ST_WB);
    assign fill_ready     = (state == ST_FILL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state           <= ST_IDLE;
            r_req           <= '0;
            r_way           <= '0;
            core_resp_valid <= 1'b0;
            core_resp_data  <= '0;
            up_inv_valid    <= 1'b0;
            up_inv_addr     <= '0;
            wb_addr         <= '0;
            wb_data         <= '0;
        end else begin
            core_resp_valid <= 1'b0;
            up_inv_valid    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (core_req_valid) begin
                        r_req.kind  <= decode_op(core_req_op);
                        r_req.addr  <= core_req_addr;
                        r_req.wdata <= core_req_wdata;
                        state <= (decode_op(core_req_op) == KIND_FETCH) ? ST_REQ : ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (hit_any) begin
                        core_resp_valid <= 1'b1;
                        core_resp_data  <= is_store ? r_req.wdata : pick_word(rd_line, r_wsel);
                        state           <= ST_IDLE;
                    end else begin
                        r_way <= victim_way;
                        if (vic_valid) begin
                            up_inv_valid <= 1'b1;
                            up_inv_addr  <= {vic_tag, r_idx, {OFF_W{1'b0}}};
                        end
                        if (vic_valid && vic_dirty) begin
                            wb_addr <= {vic_tag, r_idx, {OFF_W{1'b0}}};
                            wb_data <= rd_line;
                            state   <= ST_WB;
                        end else begin
                            state <= ST_REQ;
                        end
                    end
                end
                ST_WB: begin
                    if (wb_ready) begin
                        state <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mreq_ready) begin
                        state <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (fill_valid) begin
                        core_resp_valid <= 1'b1;
                        core_resp_data  <= is_store ? r_req.wdata : pick_word(fill_data, r_wsel);
                        state           <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sc_store_cache_chk.sv
module sc_store_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              core_req_ready,
    input logic              core_resp_valid,
    input logic              up_inv_valid,
    input logic              mreq_valid,
    input logic              mreq_ready,
    input logic [ADDR_W-1:0] mreq_addr,
    input logic              mreq_ifetch,
    input logic              fill_ready,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [LINE_W-1:0] wb_data
);

    a_r11_mreq_hold: assert property (@(posedge clk) disable iff (rst)
        (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr) && $stable(mreq_ifetch)));

    a_r11_wb_hold: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

    a_r5_wb_first: assert property (@(posedge clk) disable iff (rst)
        !(wb_valid && mreq_valid));

    a_r5_req_after_wb: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_ready) |=> mreq_valid);

    a_r9_port_closed: assert property (@(posedge clk) disable iff (rst)
        (mreq_valid || wb_valid || fill_ready) |-> !core_req_ready);

    a_r9_resp_pulse: assert property (@(posedge clk) disable iff (rst)
        core_resp_valid |=> !core_resp_valid);

    a_r7_inv_pulse: assert property (@(posedge clk) disable iff (rst)
        up_inv_valid |=> !up_inv_valid);

endmodule

bind sc_store_cache sc_store_cache_chk #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_BYTES * 8)
) i_chk (
    .clk             (clk),
    .rst             (rst),
    .core_req_ready  (core_req_ready),
    .core_resp_valid (core_resp_valid),
    .up_inv_valid    (up_inv_valid),
    .mreq_valid      (mreq_valid),
    .mreq_ready      (mreq_ready),
    .mreq_addr       (mreq_addr),
    .mreq_ifetch     (mreq_ifetch),
    .fill_ready      (fill_ready),
    .wb_valid        (wb_valid),
    .wb_ready        (wb_ready),
    .wb_addr         (wb_addr),
    .wb_data         (wb_data)
);

// File: tb/test_sc_store_cache.sv
`timescale 1ns/1ps
module test_sc_store_cache;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         core_req_valid = 1'b0;
    logic         core_req_ready;
    logic [1:0]   core_req_op = 2'd0;
    logic [31:0]  core_req_addr = '0;
    logic [31:0]  core_req_wdata = '0;
    logic         core_resp_valid;
    logic [31:0]  core_resp_data;
    logic         up_inv_valid;
    logic [31:0]  up_inv_addr;
    logic         mreq_valid;
    logic         mreq_ready = 1'b1;
    logic [31:0]  mreq_addr;
    logic         mreq_ifetch;
    logic         fill_valid = 1'b0;
    logic         fill_ready;
    logic [127:0] fill_data = '0;
    logic         wb_valid;
    logic         wb_ready = 1'b1;
    logic [31:0]  wb_addr;
    logic [127:0] wb_data;

    sc_store_cache i_sc_store_cache (.*);

    always #2 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    int req_cnt = 0, wb_cnt = 0, inv_cnt = 0;
    int req_stamp = 0, wb_stamp = 0;
    logic [31:0]  last_req_addr = '0, last_inv_addr = '0, last_wb_addr = '0;
    logic         last_req_fetch = 1'b0;
    logic [127:0] last_wb_data = '0;
    logic [127:0] mem_q [logic [31:0]];

    function automatic logic [31:0] word_val(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A5A_1234;
    endfunction

    function automatic logic [127:0] line_of(input logic [31:0] la);
        logic [127:0] l;
        if (mem_q.exists(la)) return mem_q[la];
        for (int k = 0; k < 4; k++) l[k*32 +: 32] = word_val(la + 32'(k * 4));
        return l;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // network responder and monitor; samples and drives at the falling edge
    initial begin
        bit   pending = 0, took = 0;
        int   delay = 0;
        logic [31:0] pend_addr = '0;
        forever begin
            @(negedge clk);
            if (up_inv_valid) begin inv_cnt++; last_inv_addr = up_inv_addr; end
            if (wb_valid && wb_ready) begin
                wb_cnt++; wb_stamp = cyc; last_wb_addr = wb_addr; last_wb_data = wb_data;
                mem_q[wb_addr] = wb_data;
            end
            if (fill_valid && took) begin
                fill_valid = 1'b0; pending = 0; took = 0;
            end else if (fill_valid) begin
                took = fill_ready;
            end
            if (mreq_valid && mreq_ready) begin
                req_cnt++; req_stamp = cyc; last_req_addr = mreq_addr; last_req_fetch = mreq_ifetch;
                pending = 1; pend_addr = mreq_addr; delay = 2;
            end else if (pending && !fill_valid) begin
                if (delay > 0) delay--;
                else begin
                    fill_data = line_of(pend_addr); fill_valid = 1'b1; took = fill_ready;
                end
            end
        end
    end

    task automatic access(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int open_cycles);
        @(negedge clk);
        core_req_valid = 1'b1; core_req_op = op; core_req_addr = addr; core_req_wdata = wd;
        while (!core_req_ready) @(negedge clk);
        @(negedge clk);
        core_req_valid = 1'b0;
        open_cycles = 0;
        while (!core_resp_valid) begin
            if (core_req_ready) open_cycles++;
            @(negedge clk);
        end
        rd = core_resp_data;
    endtask

    logic [31:0] rd;
    int open_c, r0, i0, w0;

    task automatic t_reset();
        chk("R1 ready after reset", core_req_ready, 1);
        chk("R1 no outputs valid", {core_resp_valid, up_inv_valid, mreq_valid, wb_valid}, 0);
    endtask

    task automatic t_load_miss();
        r0 = req_cnt;
        access(2'd0, 32'h1004, 0, rd, open_c);
        chk("R1 R3 cold load misses", req_cnt - r0, 1);
        chk("R3 line aligned request", last_req_addr, 32'h1000);
        chk("R3 fetch flag clear", last_req_fetch, 0);
        chk("R3 miss data", rd, word_val(32'h1004));
        chk("R9 port closed during miss", open_c, 0);
    endtask

    task automatic t_load_hit();
        r0 = req_cnt; w0 = wb_cnt;
        access(2'd0, 32'h100C, 0, rd, open_c);
        chk("R2 hit data", rd, word_val(32'h100C));
        chk("R2 hit no traffic", {req_cnt - r0, wb_cnt - w0}, 0);
        access(2'd3, 32'h1008, 0, rd, open_c);
        chk("R8 op 3 acts as load hit", rd, word_val(32'h1008));
    endtask

    task automatic t_store_hit();
        r0 = req_cnt; w0 = wb_cnt;
        access(2'd1, 32'h1004, 32'hDEAD_BEEF, rd, open_c);
        chk("R4 store ack data", rd, 32'hDEAD_BEEF);
        access(2'd0, 32'h1004, 0, rd, open_c);
        chk("R4 store hit readback", rd, 32'hDEAD_BEEF);
        chk("R4 store hit no traffic", {req_cnt - r0, wb_cnt - w0}, 0);
    endtask

    task automatic t_store_miss();
        r0 = req_cnt;
        access(2'd1, 32'h1808, 32'h1234_ABCD, rd, open_c);
        chk("R4 store miss fetches line", last_req_addr, 32'h1800);
        access(2'd0, 32'h1808, 0, rd, open_c);
        chk("R4 merged word", rd, 32'h1234_ABCD);
        access(2'd0, 32'h1800, 0, rd, open_c);
        chk("R4 other word from fill", rd, word_val(32'h1800));
        chk("R4 single fetch for store miss", req_cnt - r0, 1);
        chk("R7 no invalidate into free ways", inv_cnt, 0);
    endtask

    task automatic t_fetch();
        r0 = req_cnt; i0 = inv_cnt;
        access(2'd2, 32'h2004, 0, rd, open_c);
        chk("R8 fetch data", rd, word_val(32'h2004));
        chk("R8 fetch flag set", last_req_fetch, 1);
        access(2'd0, 32'h2004, 0, rd, open_c);
        chk("R8 fetch did not allocate", req_cnt - r0, 2);
        chk("R8 fetch no invalidate", inv_cnt - i0, 0);
        access(2'd0, 32'h2800, 0, rd, open_c);
        chk("R10 fourth way filled", rd, word_val(32'h2800));
    endtask

    task automatic t_plru_clean();
        access(2'd0, 32'h1000, 0, rd, open_c);
        r0 = req_cnt; i0 = inv_cnt; w0 = wb_cnt;
        access(2'd0, 32'h3000, 0, rd, open_c);
        chk("R10 tree picks way 2", last_inv_addr, 32'h2000);
        chk("R7 invalidate on eviction", inv_cnt - i0, 1);
        chk("R6 clean victim no writeback", wb_cnt - w0, 0);
        access(2'd0, 32'h2804, 0, rd, open_c);
        chk("R10 way 3 kept", req_cnt - r0, 1);
    endtask

    task automatic t_dirty_evict();
        i0 = inv_cnt; w0 = wb_cnt;
        @(posedge clk); #1 wb_ready = 1'b0;
        fork
            access(2'd0, 32'h3800, 0, rd, open_c);
            begin
                repeat (8) @(negedge clk);
                chk("R11 writeback held", {wb_valid, wb_addr}, {1'b1, 32'h1800});
                chk("R5 request waits for writeback", mreq_valid, 0);
                @(posedge clk); #1 wb_ready = 1'b1;
            end
        join
        chk("R5 one writeback", wb_cnt - w0, 1);
        chk("R5 writeback address", last_wb_addr, 32'h1800);
        chk("R5 writeback data", last_wb_data[95:64], 32'h1234_ABCD);
        chk("R5 writeback before request", wb_stamp < req_stamp, 1);
        chk("R7 dirty victim invalidated", last_inv_addr, 32'h1800);
        chk("R3 new line data", rd, word_val(32'h3800));
        access(2'd0, 32'h1808, 0, rd, open_c);
        chk("R5 written data survives", rd, 32'h1234_ABCD);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_miss();
        t_load_hit();
        t_store_hit();
        t_store_miss();
        t_fetch();
        t_plru_clean();
        t_dirty_evict();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule